// File: doc/BRIEF.md
# Frame-Synchronous Control and Voice Timeslot Port

This block serves one serial TDM line that carries a fixed number of 8-bit channels per frame, with a frame pulse that marks where the frame begins. It counts bit clocks from that pulse and picks out three channels. Channel 1 is a control byte. Channel 2 and channel 3 are two voice channels that carry codec PCM. For each of these channels the block either drives the outgoing serial line or leaves it released. It also shifts in the incoming serial line and captures the bytes it needs.

A small register bus sets up the port. A control register holds three fields: the control-channel enable, the transmit voice select and the receive voice select. The two selects act independently, so the codec can send on one voice channel and listen on the other. A second address holds the outgoing control byte when written and returns the last received control byte when read. A self-clearing soft-reset bit in the control register restores the outgoing control byte to all ones. The outgoing data travels with a separate output-enable. Any channel the port does not own, and any owned channel that is switched off, leaves the enable low, so the pad stays tri-stated.

A two-state machine does the timing. In `ST_HUNT` the block waits for the first frame pulse. The transition *lock* (a frame pulse is seen) moves it to `ST_RUN`. In `ST_RUN` there are two transitions. *Wrap* returns the bit counter to zero after the last bit of the frame. *Realign* zeroes the counter whenever a new frame pulse arrives. There is no transition back to `ST_HUNT` except through reset.

Top module: `tsport_top`

## Requirements
- R1: After reset the control register reads 0 (enable off, both selects 0), the outgoing control byte is 8'hFF, the received control byte reads 0 and `ser_oe` is low.
- R2: Before the first frame pulse (`ST_HUNT`), `ser_oe` stays low even with the control-channel enable set, and no received byte is captured.
- R3: A clock period in which `frame_pulse` is high is followed by bit 0 of channel 0. Channel n occupies bit periods 8n to 8n+7. A frame pulse that arrives in the middle of a frame restarts the count.
- R4: With the control enable (control bit 0) set, channel 1 carries the outgoing control byte (written at address 1), most significant bit first. The byte is taken at the start of the frame.
- R5: With the control enable clear, `ser_oe` is low for all of channel 1.
- R6: The byte received in channel 1 is stored whatever the enable state, and it reads back at address 1.
- R7: Writing the control register with bit 5 set puts 8'hFF into the outgoing control byte. Bit 5 is not stored and reads back as 0.
- R8: The transmit select (control bits 2:1) sends the codec transmit byte `tx_pcm`, taken at frame start and sent MSB first: 1 in channel 2, 2 in channel 3. The values 0 and 3 leave both voice channels tri-stated.
- R9: The receive select (control bits 4:3) uses the same encoding as the transmit select and is independent of it. The selected channel's byte appears on `rx_pcm` together with a one-cycle `rx_pcm_valid`. With no valid receive select there is no pulse and `rx_pcm` holds its value.
- R10: `ser_oe` is low in every channel other than 1, 2 and 3.
- R11: `ser_out` and `ser_oe` change only on the falling clock edge. `ser_in` is sampled on the rising edge. When `ser_oe` is low, `ser_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| frame_pulse | input | 1 | High for the bit period before bit 0 of channel 0 |
| ser_in | input | 1 | Incoming serial line |
| ser_out | output | 1 | Outgoing serial data |
| ser_oe | output | 1 | Output enable for the outgoing line (low = tri-state) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 control byte) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| tx_pcm | input | 8 | Codec byte to transmit, taken at frame start |
| rx_pcm | output | 8 | Last received codec byte |
| rx_pcm_valid | output | 1 | One-cycle strobe when `rx_pcm` updates |

## Verification
The assertions assume that `frame_pulse` is only one cycle wide. They also assume that all inputs settle between the edges, so that the rising-edge sampling and the falling-edge drive see stable values. The bench changes every input a nanosecond after a falling edge. It then deliberately flips `ser_in` just after each rising edge, so only the value present at the rising edge can reach the captured bytes. Register writes and `tx_pcm` changes are finished before the frame-start edge that takes their snapshot. One frame pulse is deliberately placed in the middle of a frame to exercise *realign*.

// File: rtl/tsport_pkg.sv
`timescale 1ns/1ps
package tsport_pkg;

    typedef enum logic [1:0] {
        SK_IDLE,
        SK_CTRL,
        SK_VOICE1,
        SK_VOICE2
    } slot_kind_t;

    typedef enum logic {
        ST_HUNT,
        ST_RUN
    } sync_state_t;

    // control register layout: {rx_sel, tx_sel, c_en}
    typedef struct packed {
        logic [1:0] rx_sel;
        logic [1:0] tx_sel;
        logic       c_en;
    } port_cfg_t;

    localparam logic [1:0] SEL_VOICE1 = 2'd1;
    localparam logic [1:0] SEL_VOICE2 = 2'd2;
    localparam int         SOFT_RST_BIT = 5;

endpackage

// File: rtl/tsport_timer.sv
`timescale 1ns/1ps
module tsport_timer
    import tsport_pkg::*;
#(
    parameter int SLOT_W    = 8,
    parameter int NUM_SLOTS = 32,
    parameter int C_SLOT    = 1,
    parameter int B1_SLOT   = 2,
    parameter int B2_SLOT   = 3,
    localparam int FRAME_BITS = SLOT_W * NUM_SLOTS,
    localparam int CNT_W      = $clog2(FRAME_BITS),
    localparam int BIT_W      = $clog2(SLOT_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_pulse,
    output logic             locked_o,
    output logic             frame_load_o,
    output slot_kind_t       kind_o,
    output logic [BIT_W-1:0] bit_pos_o,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);

    sync_state_t      state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic [CNT_W-1:0] slot_num;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_HUNT;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // transitions: lock, wrap, realign
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            ST_HUNT: begin
                if (frame_pulse) begin
                    state_nx = ST_RUN;
                    cnt_nx   = '0;
                end
            end
            ST_RUN: begin
                if (frame_pulse || cnt == LAST_BIT) cnt_nx = '0;
                else                                cnt_nx = cnt + 1'b1;
            end
        endcase
    end

    // outputs
    always_comb begin
        slot_num     = cnt / CNT_W'(SLOT_W);
        bit_pos_o    = BIT_W'(cnt % CNT_W'(SLOT_W));
        locked_o     = (state == ST_RUN);
        frame_load_o = frame_pulse || (state == ST_RUN && cnt == LAST_BIT);
        cnt_o        = cnt;
        kind_o       = SK_IDLE;
        if (state == ST_RUN) begin
            if      (slot_num == CNT_W'(C_SLOT))  kind_o = SK_CTRL;
            else if (slot_num == CNT_W'(B1_SLOT)) kind_o = SK_VOICE1;
            else if (slot_num == CNT_W'(B2_SLOT)) kind_o = SK_VOICE2;
        end
    end

endmodule

// File: rtl/tsport_regs.sv
`timescale 1ns/1ps
module tsport_regs
    import tsport_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] c_rx,
    output port_cfg_t         cfg,
    output logic [DATA_W-1:0] c_tx,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_CHAN = ADDR_W'(1);
    localparam int CFG_W = $bits(port_cfg_t);

    logic unused_wbits;
    assign unused_wbits = ^wdata[DATA_W-1:SOFT_RST_BIT+1] ^ wdata[CFG_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg  <= '0;
            c_tx <= '1;
        end else if (we) begin
            if (addr == A_CTRL) begin
                cfg <= port_cfg_t'(wdata[CFG_W-1:0]);
                if (wdata[SOFT_RST_BIT]) c_tx <= '1;
            end else if (addr == A_CHAN) begin
                c_tx <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        if      (addr == A_CTRL) rdata[CFG_W-1:0] = cfg;
        else if (addr == A_CHAN) rdata = c_rx;
    end

endmodule

// File: rtl/tsport_tx.sv
`timescale 1ns/1ps
module tsport_tx
    import tsport_pkg::*;
#(
    parameter int SLOT_W = 8,
    localparam int BIT_W = $clog2(SLOT_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_load,
    input  logic              locked,
    input  slot_kind_t        kind,
    input  logic [BIT_W-1:0]  bit_pos,
    input  port_cfg_t         cfg,
    input  logic [SLOT_W-1:0] c_tx,
    input  logic [SLOT_W-1:0] tx_pcm,
    output logic              ser_out,
    output logic              ser_oe
);

    logic [SLOT_W-1:0] c_snap, b_snap;
    logic              drive_c, drive_b, drive_nx, bit_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_snap <= '1;
            b_snap <= '0;
        end else if (frame_load) begin
            c_snap <= c_tx;
            b_snap <= tx_pcm;
        end
    end

    always_comb begin
        drive_c  = locked && kind == SK_CTRL && cfg.c_en;
        drive_b  = locked && ((kind == SK_VOICE1 && cfg.tx_sel == SEL_VOICE1) ||
                              (kind == SK_VOICE2 && cfg.tx_sel == SEL_VOICE2));
        drive_nx = drive_c || drive_b;
        bit_nx   = 1'b0;
        if (drive_c)      bit_nx = c_snap[SLOT_W-1-int'(bit_pos)];
        else if (drive_b) bit_nx = b_snap[SLOT_W-1-int'(bit_pos)];
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ser_oe  <= 1'b0;
            ser_out <= 1'b0;
        end else begin
            ser_oe  <= drive_nx;
            ser_out <= bit_nx;
        end
    end

endmodule

// File: rtl/tsport_rx.sv
`timescale 1ns/1ps
module tsport_rx
    import tsport_pkg::*;
#(
    parameter int SLOT_W = 8,
    localparam int BIT_W = $clog2(SLOT_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              locked,
    input  slot_kind_t        kind,
    input  logic [BIT_W-1:0]  bit_pos,
    input  port_cfg_t         cfg,
    input  logic              ser_in,
    output logic [SLOT_W-1:0] c_rx,
    output logic [SLOT_W-1:0] rx_pcm,
    output logic              rx_pcm_valid
);

    localparam logic [BIT_W-1:0] LAST_POS = BIT_W'(SLOT_W - 1);

    logic [SLOT_W-1:0] shreg;
    logic [SLOT_W-1:0] full_byte;
    logic              slot_end, take_b;

    always_comb begin
        full_byte = {shreg[SLOT_W-2:0], ser_in};
        slot_end  = locked && bit_pos == LAST_POS;
        take_b    = (kind == SK_VOICE1 && cfg.rx_sel == SEL_VOICE1) ||
                    (kind == SK_VOICE2 && cfg.rx_sel == SEL_VOICE2);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg        <= '0;
            c_rx         <= '0;
            rx_pcm       <= '0;
            rx_pcm_valid <= 1'b0;
        end else begin
            shreg        <= full_byte;
            rx_pcm_valid <= 1'b0;
            if (slot_end && kind == SK_CTRL) c_rx <= full_byte;
            if (slot_end && take_b) begin
                rx_pcm       <= full_byte;
                rx_pcm_valid <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/tsport_top.sv
`timescale 1ns/1ps
module tsport_top
    import tsport_pkg::*;
#(
    parameter int SLOT_W    = 8,
    parameter int NUM_SLOTS = 32,
    parameter int C_SLOT    = 1,
    parameter int B1_SLOT   = 2,
    parameter int B2_SLOT   = 3,
    parameter int ADDR_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_pulse,
    input  logic              ser_in,
    output logic              ser_out,
    output logic              ser_oe,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [SLOT_W-1:0] reg_wdata,
    output logic [SLOT_W-1:0] reg_rdata,
    input  logic [SLOT_W-1:0] tx_pcm,
    output logic [SLOT_W-1:0] rx_pcm,
    output logic              rx_pcm_valid
);

    localparam int FRAME_BITS = SLOT_W * NUM_SLOTS;
    localparam int CNT_W      = $clog2(FRAME_BITS);
    localparam int BIT_W      = $clog2(SLOT_W);

    logic              locked, frame_load;
    slot_kind_t        kind;
    logic [BIT_W-1:0]  bit_pos;
    logic [CNT_W-1:0]  cnt;
    port_cfg_t         cfg;
    logic [SLOT_W-1:0] c_tx, c_rx;

    tsport_timer #(
        .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS),
        .C_SLOT(C_SLOT), .B1_SLOT(B1_SLOT), .B2_SLOT(B2_SLOT)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse),
        .locked_o(locked), .frame_load_o(frame_load),
        .kind_o(kind), .bit_pos_o(bit_pos), .cnt_o(cnt)
    );

    tsport_regs #(.DATA_W(SLOT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .c_rx(c_rx), .cfg(cfg), .c_tx(c_tx),
        .rdata(reg_rdata)
    );

    tsport_tx #(.SLOT_W(SLOT_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .frame_load(frame_load),
        .locked(locked), .kind(kind), .bit_pos(bit_pos), .cfg(cfg),
        .c_tx(c_tx), .tx_pcm(tx_pcm), .ser_out(ser_out), .ser_oe(ser_oe)
    );

    tsport_rx #(.SLOT_W(SLOT_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .locked(locked), .kind(kind),
        .bit_pos(bit_pos), .cfg(cfg), .ser_in(ser_in), .c_rx(c_rx),
        .rx_pcm(rx_pcm), .rx_pcm_valid(rx_pcm_valid)
    );

endmodule

// File: rtl/tsport_chk.sv
`timescale 1ns/1ps
module tsport_chk
    import tsport_pkg::*;
#(
    parameter int SLOT_W     = 8,
    parameter int FRAME_BITS = 256,
    localparam int CNT_W     = $clog2(FRAME_BITS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_pulse,
    input logic              locked,
    input slot_kind_t        kind,
    input logic [CNT_W-1:0]  cnt,
    input logic              c_en,
    input logic              ser_out,
    input logic              ser_oe,
    input logic [SLOT_W-1:0] rx_pcm,
    input logic              rx_pcm_valid
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);

    p_hunt_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |-> !ser_oe);

    p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !frame_pulse && cnt != LAST_BIT) |=> cnt == $past(cnt) + 1'b1);

    p_ctrl_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == SK_CTRL && !c_en) |-> !ser_oe);

    p_valid_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pcm_valid |=> !rx_pcm_valid);

    p_pcm_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_pcm_valid |=> (rx_pcm_valid || $stable(rx_pcm)));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        kind == SK_IDLE |-> !ser_oe);

    p_released_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_oe |-> !ser_out);

endmodule

bind tsport_top tsport_chk #(.SLOT_W(SLOT_W), .FRAME_BITS(FRAME_BITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse), .locked(locked),
    .kind(kind), .cnt(cnt), .c_en(cfg.c_en), .ser_out(ser_out),
    .ser_oe(ser_oe), .rx_pcm(rx_pcm), .rx_pcm_valid(rx_pcm_valid)
);

// File: tb/sim_tsport_top.sv
`timescale 1ns/1ps
module sim_tsport_top;

    localparam int FB = 256;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_pulse = 1'b0;
    logic       ser_in = 1'b1;
    logic       ser_out, ser_oe;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic [7:0] tx_pcm = 8'd0;
    logic [7:0] rx_pcm;
    logic       rx_pcm_valid;

    always #2 clk = ~clk;

    tsport_top u0 (
        .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse), .ser_in(ser_in),
        .ser_out(ser_out), .ser_oe(ser_oe), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_pcm(tx_pcm), .rx_pcm(rx_pcm), .rx_pcm_valid(rx_pcm_valid)
    );

    int   n_checks = 0;
    int   n_errors = 0;
    logic fr_out  [FB];
    logic fr_oe   [FB];
    logic fr_hold [FB];
    int   fr_valid;
    logic [7:0] drv_c = 8'h00, drv_b1 = 8'h00, drv_b2 = 8'h00;
    logic [7:0] rd;

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); #1;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic in_bit(input int pos);
        int s = pos / 8;
        int b = 7 - pos % 8;
        case (s)
            1:       return drv_c[b];
            2:       return drv_b1[b];
            3:       return drv_b2[b];
            default: return 1'b1;
        endcase
    endfunction

    // one full frame started by a frame pulse; ser_in is flipped after each
    // rising edge so only the value present at that edge is meaningful
    task automatic run_frame();
        @(negedge clk); #1;
        frame_pulse = 1'b1; ser_in = 1'b1;
        fr_valid = 0;
        for (int p = 0; p < FB; p++) begin
            @(negedge clk); #1;
            frame_pulse = 1'b0;
            fr_out[p] = ser_out;
            fr_oe[p]  = ser_oe;
            if (rx_pcm_valid) fr_valid++;
            ser_in = in_bit(p);
            @(posedge clk); #1;
            fr_hold[p] = ser_out;
            ser_in = ~ser_in;
        end
    endtask

    function automatic int byte_of(input int s);
        logic [7:0] v;
        for (int b = 0; b < 8; b++) v[7-b] = fr_out[s*8+b];
        return int'(v);
    endfunction

    function automatic int oe_cnt(input int s);
        int n = 0;
        for (int b = 0; b < 8; b++) n += int'(fr_oe[s*8+b]);
        return n;
    endfunction

    function automatic int other_oe();
        int n = 0;
        for (int s = 0; s < FB/8; s++)
            if (s < 1 || s > 3) n += oe_cnt(s);
        return n;
    endfunction

    function automatic int hold_mismatch();
        int n = 0;
        for (int p = 0; p < FB; p++) n += int'(fr_hold[p] != fr_out[p]);
        return n;
    endfunction

    task automatic t_reset();
        reg_read(2'd0, rd); chk("R1 ctrl after reset", rd, 8'h00);
        reg_read(2'd1, rd); chk("R1 rx ctrl byte after reset", rd, 8'h00);
        chk("R1 oe after reset", ser_oe, 0);
    endtask

    task automatic t_hunt();
        int seen = 0;
        reg_write(2'd0, 8'h01);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk); #1;
            ser_in = i[0];
            seen += int'(ser_oe);
        end
        chk("R2 no drive before frame pulse", seen, 0);
        reg_read(2'd1, rd); chk("R2 no capture before frame pulse", rd, 8'h00);
    endtask

    task automatic t_c_default();
        drv_c = 8'hA5;
        run_frame();
        chk("R1 default ctrl byte FF", byte_of(1), 8'hFF);
        chk("R3 channel 0 quiet", oe_cnt(0), 0);
        chk("R4 channel 1 fully driven", oe_cnt(1), 8);
        chk("R10 other channels quiet", other_oe(), 0);
        reg_read(2'd1, rd); chk("R6 rx ctrl byte", rd, 8'hA5);
    endtask

    task automatic t_c_data();
        reg_write(2'd1, 8'h3C);
        drv_c = 8'hC3;
        run_frame();
        chk("R4 ctrl byte MSB first", byte_of(1), 8'h3C);
        chk("R11 output holds across rising edge", hold_mismatch(), 0);
        reg_read(2'd1, rd); chk("R11 rising edge sampling", rd, 8'hC3);
    endtask

    task automatic t_c_disable();
        reg_write(2'd0, 8'h00);
        drv_c = 8'h5A;
        run_frame();
        chk("R5 channel 1 released", oe_cnt(1), 0);
        chk("R11 released line reads 0", byte_of(1), 0);
        reg_read(2'd1, rd); chk("R6 capture with enable off", rd, 8'h5A);
    endtask

    task automatic t_soft_reset();
        reg_write(2'd1, 8'h12);
        reg_write(2'd0, 8'h21);
        reg_read(2'd0, rd); chk("R7 soft reset bit not kept", rd, 8'h01);
        run_frame();
        chk("R7 soft reset restores FF", byte_of(1), 8'hFF);
    endtask

    task automatic t_b_tx();
        reg_write(2'd0, 8'h02);
        tx_pcm = 8'h96;
        run_frame();
        chk("R8 voice1 data", byte_of(2), 8'h96);
        chk("R8 voice1 driven", oe_cnt(2), 8);
        chk("R8 voice2 quiet", oe_cnt(3), 0);
        chk("R9 no rx pulse without select", fr_valid, 0);
        reg_write(2'd0, 8'h04);
        tx_pcm = 8'h4D;
        run_frame();
        chk("R8 voice2 data", byte_of(3), 8'h4D);
        chk("R8 voice1 quiet", oe_cnt(2), 0);
        reg_write(2'd0, 8'h06);
        run_frame();
        chk("R8 select 3 releases voice", oe_cnt(2) + oe_cnt(3), 0);
    endtask

    task automatic t_b_rx();
        reg_write(2'd0, 8'h0C);
        tx_pcm = 8'hE1;
        drv_b1 = 8'hC3; drv_b2 = 8'h7E;
        run_frame();
        chk("R9 rx voice1 byte", rx_pcm, 8'hC3);
        chk("R9 one valid pulse", fr_valid, 1);
        chk("R9 tx on voice2 independently", byte_of(3), 8'hE1);
        chk("R9 tx voice1 quiet", oe_cnt(2), 0);
        reg_write(2'd0, 8'h10);
        run_frame();
        chk("R9 rx voice2 byte", rx_pcm, 8'h7E);
        reg_write(2'd0, 8'h18);
        drv_b2 = 8'h11;
        run_frame();
        chk("R9 invalid select no pulse", fr_valid, 0);
        chk("R9 rx byte held", rx_pcm, 8'h7E);
    endtask

    task automatic t_realign();
        reg_write(2'd0, 8'h01);
        reg_write(2'd1, 8'h69);
        drv_c = 8'h2B;
        repeat (77) @(negedge clk);
        run_frame();
        chk("R3 mid-frame realign ctrl byte", byte_of(1), 8'h69);
        chk("R3 realign channel 0 quiet", oe_cnt(0), 0);
        reg_read(2'd1, rd); chk("R3 realign rx ctrl byte", rd, 8'h2B);
    endtask

    logic done = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_hunt();
        t_c_default();
        t_c_data();
        t_c_disable();
        t_soft_reset();
        t_b_tx();
        t_b_rx();
        t_realign();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule